// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block sits beside the instruction decoder of a RISC-V style core. For each decoded instruction it decides whether an illegal-instruction or environment-call exception must be raised. It uses the current privilege mode, a few fields of the machine status word and a handful of flags from the decoder:
- a read of the address-translation CSR
- a write of the address-translation CSR
- a translation-cache fence
- a floating-point operation
- an environment call

The decision and its cause code are registered, so they appear one clock after the instruction is presented.

Two gates are applied. When the trap-virtual-memory control (status bit 20) is set, supervisor mode may not touch the translation CSR or execute the fence. When the floating-point state field (status bits 14:13) is off (00), every floating-point instruction is illegal. An environment call is reported with a cause code that depends on the mode.

The block also produces the read view of the status word. In that view the top bit is replaced by the summary dirty bit, which is set exactly when the floating-point state field is 11. The width of the status word is a parameter.

Top module: `priv_legality_check`

## Requirements
- R1: While reset is high and on the first cycle after it, `trap_req`, `trap_cause` and `status_rd` are all zero.
- R2: With `priv_mode`=01 (supervisor) and status bit 20 set, a valid read or write of the translation CSR gives `trap_req`=1 with `trap_cause`=2 on the next cycle.
- R3: With `priv_mode`=01 and status bit 20 set, a valid translation-cache fence gives `trap_req`=1 with `trap_cause`=2 on the next cycle.
- R4: Status bit 20 has no effect in machine mode (`priv_mode`=11). When that bit is clear, translation CSR access and the fence are legal in supervisor mode: `trap_req` stays 0.
- R5: A valid floating-point instruction while status bits 14:13 are 00 gives `trap_req`=1 with `trap_cause`=2 on the next cycle, in any mode.
- R6: A valid environment call gives `trap_req`=1 on the next cycle. Its cause is 11 from `priv_mode`=11, 9 from `priv_mode`=01 and 8 from `priv_mode`=00.
- R7: Only one cause is reported per instruction. The floating-point gate wins over the translation gate, and the translation gate wins over the environment call.
- R8: When `instr_valid` is 0, the next cycle shows `trap_req`=0 and `trap_cause`=0, whatever the flags are.
- R9: One cycle after a status value is presented, `status_rd` shows that value with its top bit replaced by (bits 14:13 == 11). A field value of 10 reads with the top bit clear.
- R10: A floating-point instruction with bits 14:13 not equal to 00 raises no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Decoded instruction is real (not a bubble) |
| priv_mode | input | 2 | Current mode: 00 user, 01 supervisor, 11 machine |
| status_in | input | XLEN | Machine status word |
| op_xlat_rd | input | 1 | Instruction reads the translation CSR |
| op_xlat_wr | input | 1 | Instruction writes the translation CSR |
| op_xlat_fence | input | 1 | Instruction is a translation-cache fence |
| op_fp | input | 1 | Instruction is a floating-point operation |
| op_ecall | input | 1 | Instruction is an environment call |
| trap_req | output | 1 | Exception request, one cycle after the instruction |
| trap_cause | output | 4 | Cause code of the request, 0 when none |
| status_rd | output | XLEN | Status read view with the summary dirty bit on top |

## Verification
The translation flags are tried in supervisor mode with the control bit set and with it clear, and again in machine mode with the bit set. This separates a gate keyed on the bit alone from one keyed on bit and mode. The floating-point flag is swept over all four state-field values, which shows that only 00 traps. Instructions carrying several flags at once are used to show the order between the gates. Status words whose top bit disagrees with the dirty condition show that the summary bit is computed, not copied.

// File: rtl/plc_pkg.sv
package plc_pkg;
    localparam int CAUSE_W  = 4;
    localparam int TVM_POS  = 20;
    localparam int FS_LO    = 13;
    localparam int FS_W     = 2;

    typedef enum logic [1:0] {
        MODE_USER = 2'b00,
        MODE_SUPV = 2'b01,
        MODE_RSVD = 2'b10,
        MODE_MACH = 2'b11
    } mode_t;

    typedef logic [CAUSE_W-1:0] cause_t;

    localparam cause_t CAUSE_ILLEGAL = cause_t'(2);
    localparam cause_t CAUSE_ENV_U   = cause_t'(8);
    localparam cause_t CAUSE_ENV_S   = cause_t'(9);
    localparam cause_t CAUSE_ENV_M   = cause_t'(11);

    typedef struct packed {
        logic   req;
        cause_t code;
    } trap_t;

    function automatic cause_t env_code(mode_t m);
        case (m)
            MODE_MACH: env_code = CAUSE_ENV_M;
            MODE_SUPV: env_code = CAUSE_ENV_S;
            default:   env_code = CAUSE_ENV_U;
        endcase
    endfunction

    function automatic trap_t pick_trap(logic fp_hit, logic vm_hit,
                                        logic env_hit, cause_t env_c);
        trap_t t;
        t = '0;
        if (fp_hit || vm_hit) begin
            t.req  = 1'b1;
            t.code = CAUSE_ILLEGAL;
        end else if (env_hit) begin
            t.req  = 1'b1;
            t.code = env_c;
        end
        return t;
    endfunction
endpackage

// File: rtl/plc_vm_guard.sv
module plc_vm_guard
    import plc_pkg::*;
(
    input  mode_t mode,
    input  logic  tvm,
    input  logic  xlat_rd,
    input  logic  xlat_wr,
    input  logic  xlat_fence,
    output logic  hit
);
    logic touches;
    always_comb begin
        touches = xlat_rd | xlat_wr | xlat_fence;
        hit     = (mode == MODE_SUPV) & tvm & touches;
    end
endmodule

// File: rtl/plc_fp_guard.sv
module plc_fp_guard
    import plc_pkg::*;
(
    input  logic [FS_W-1:0] fs,
    input  logic            fp_op,
    output logic            hit
);
    always_comb hit = fp_op & (fs == '0);
endmodule

// File: rtl/plc_env_code.sv
module plc_env_code
    import plc_pkg::*;
(
    input  mode_t  mode,
    input  logic   ecall,
    output logic   hit,
    output cause_t code
);
    always_comb begin
        hit  = ecall;
        code = env_code(mode);
    end
endmodule

// File: rtl/plc_dirty_view.sv
module plc_dirty_view
    import plc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] status,
    output logic [XLEN-1:0] view
);
    localparam int TOP = XLEN - 1;
    logic summary;
    always_comb summary = &status[FS_LO +: FS_W];

    generate
        if (XLEN == 32 || XLEN == 64) begin : g_ok
            always_comb view = {summary, status[TOP-1:0]};
        end else begin : g_bad
            initial $error("plc_dirty_view: XLEN must be 32 or 64");
            always_comb view = {summary, status[TOP-1:0]};
        end
    endgenerate
endmodule

// File: rtl/priv_legality_check.sv
module priv_legality_check
    import plc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_valid,
    input  logic [1:0]          priv_mode,
    input  logic [XLEN-1:0]     status_in,
    input  logic                op_xlat_rd,
    input  logic                op_xlat_wr,
    input  logic                op_xlat_fence,
    input  logic                op_fp,
    input  logic                op_ecall,
    output logic                trap_req,
    output logic [CAUSE_W-1:0]  trap_cause,
    output logic [XLEN-1:0]     status_rd
);
    mode_t           mode;
    logic            vm_hit, fp_hit, env_hit;
    cause_t          env_c;
    trap_t           trap_d, trap_q;
    logic [XLEN-1:0] view_d, view_q;

    always_comb mode = mode_t'(priv_mode);

    plc_vm_guard u_vm (
        .mode       (mode),
        .tvm        (status_in[TVM_POS]),
        .xlat_rd    (op_xlat_rd),
        .xlat_wr    (op_xlat_wr),
        .xlat_fence (op_xlat_fence),
        .hit        (vm_hit)
    );

    plc_fp_guard u_fp (
        .fs    (status_in[FS_LO +: FS_W]),
        .fp_op (op_fp),
        .hit   (fp_hit)
    );

    plc_env_code u_env (
        .mode  (mode),
        .ecall (op_ecall),
        .hit   (env_hit),
        .code  (env_c)
    );

    plc_dirty_view #(.XLEN(XLEN)) u_view (
        .status (status_in),
        .view   (view_d)
    );

    always_comb begin
        trap_d = pick_trap(fp_hit, vm_hit, env_hit, env_c);
        if (!instr_valid) trap_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_q <= '0;
            view_q <= '0;
        end else begin
            trap_q <= trap_d;
            view_q <= view_d;
        end
    end

    assign trap_req   = trap_q.req;
    assign trap_cause = trap_q.code;
    assign status_rd  = view_q;
endmodule

// File: rtl/plc_checker.sv
module plc_checker
    import plc_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               instr_valid,
    input logic [1:0]         priv_mode,
    input logic               tvm,
    input logic [FS_W-1:0]    fs,
    input logic               op_xlat_rd,
    input logic               op_xlat_wr,
    input logic               op_xlat_fence,
    input logic               op_fp,
    input logic               op_ecall,
    input logic               trap_req,
    input logic [CAUSE_W-1:0] trap_cause,
    input logic               view_top
);
    logic vm_cond;
    assign vm_cond = (priv_mode == 2'b01) && tvm &&
                     (op_xlat_rd || op_xlat_wr || op_xlat_fence);

    assert_bubble_R8: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |=> (!trap_req && trap_cause == '0));

    assert_vm_trap_R2: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && vm_cond) |=> (trap_req && trap_cause == CAUSE_ILLEGAL));

    assert_fp_trap_R5: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && op_fp && fs == '0) |=> (trap_req && trap_cause == CAUSE_ILLEGAL));

    assert_mach_legal_R4: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && priv_mode == 2'b11 && !op_fp && !op_ecall) |=> !trap_req);

    assert_env_mach_R6: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && op_ecall && !op_fp && priv_mode == 2'b11)
        |=> (trap_req && trap_cause == CAUSE_ENV_M));

    assert_summary_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (view_top == ($past(fs) == 2'b11)));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !trap_req |-> trap_cause == '0);
endmodule

bind priv_legality_check plc_checker u_plc_checker (
    .clk           (clk),
    .rst           (rst),
    .instr_valid   (instr_valid),
    .priv_mode     (priv_mode),
    .tvm           (status_in[plc_pkg::TVM_POS]),
    .fs            (status_in[plc_pkg::FS_LO +: plc_pkg::FS_W]),
    .op_xlat_rd    (op_xlat_rd),
    .op_xlat_wr    (op_xlat_wr),
    .op_xlat_fence (op_xlat_fence),
    .op_fp         (op_fp),
    .op_ecall      (op_ecall),
    .trap_req      (trap_req),
    .trap_cause    (trap_cause),
    .view_top      (status_rd[XLEN-1])
);

// File: tb/test_priv_legality_check.sv
module test_priv_legality_check;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 64;
    localparam logic [XLEN-1:0] TVM = 64'h0000_0000_0010_0000;
    localparam logic [XLEN-1:0] FS_INIT = 64'h0000_0000_0000_2000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            instr_valid = 1'b0;
    logic [1:0]      priv_mode = 2'b11;
    logic [XLEN-1:0] status_in = '0;
    logic            op_xlat_rd = 1'b0, op_xlat_wr = 1'b0, op_xlat_fence = 1'b0;
    logic            op_fp = 1'b0, op_ecall = 1'b0;
    logic            trap_req;
    logic [3:0]      trap_cause;
    logic [XLEN-1:0] status_rd;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    priv_legality_check #(.XLEN(XLEN)) i_priv_legality_check (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .priv_mode(priv_mode),
        .status_in(status_in), .op_xlat_rd(op_xlat_rd), .op_xlat_wr(op_xlat_wr),
        .op_xlat_fence(op_xlat_fence), .op_fp(op_fp), .op_ecall(op_ecall),
        .trap_req(trap_req), .trap_cause(trap_cause), .status_rd(status_rd)
    );

    task automatic cmp(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // present one instruction at a falling edge, sample at the next falling edge
    task automatic issue(logic v, logic [1:0] m, logic [XLEN-1:0] st,
                         logic rd, logic wr, logic fe, logic fp, logic ec);
        @(negedge clk);
        instr_valid = v; priv_mode = m; status_in = st;
        op_xlat_rd = rd; op_xlat_wr = wr; op_xlat_fence = fe;
        op_fp = fp; op_ecall = ec;
        @(negedge clk);
    endtask

    task automatic expect_trap(string req, logic r, logic [3:0] c);
        cmp(req, {63'd0, trap_req}, {63'd0, r});
        cmp(req, {60'd0, trap_cause}, {60'd0, c});
    endtask

    task automatic t_reset;
        @(negedge clk);
        expect_trap("R1", 1'b0, 4'd0);
        cmp("R1", status_rd, '0);
        rst = 1'b0;
        @(negedge clk);
        expect_trap("R1", 1'b0, 4'd0);
        cmp("R1", status_rd, '0);
    endtask

    task automatic t_tvm_supervisor;
        issue(1, 2'b01, TVM | FS_INIT, 0, 1, 0, 0, 0); expect_trap("R2 write", 1, 4'd2);
        issue(1, 2'b01, TVM | FS_INIT, 1, 0, 0, 0, 0); expect_trap("R2 read", 1, 4'd2);
        issue(1, 2'b01, TVM | FS_INIT, 0, 0, 1, 0, 0); expect_trap("R3 fence", 1, 4'd2);
    endtask

    task automatic t_tvm_inert;
        issue(1, 2'b11, TVM | FS_INIT, 0, 1, 0, 0, 0); expect_trap("R4 mach wr", 0, 4'd0);
        issue(1, 2'b11, TVM | FS_INIT, 1, 0, 0, 0, 0); expect_trap("R4 mach rd", 0, 4'd0);
        issue(1, 2'b11, TVM | FS_INIT, 0, 0, 1, 0, 0); expect_trap("R4 mach fence", 0, 4'd0);
        issue(1, 2'b01, FS_INIT, 1, 1, 1, 0, 0);       expect_trap("R4 supv clear", 0, 4'd0);
    endtask

    task automatic t_fp_gate;
        for (int f = 0; f < 4; f++) begin
            logic [XLEN-1:0] st;
            st = XLEN'(f) << 13;
            issue(1, 2'b00, st, 0, 0, 0, 1, 0);
            if (f == 0) expect_trap("R5", 1, 4'd2);
            else        expect_trap("R10", 0, 4'd0);
        end
        issue(1, 2'b11, '0, 0, 0, 0, 1, 0); expect_trap("R5 mach", 1, 4'd2);
    endtask

    task automatic t_ecall;
        issue(1, 2'b11, FS_INIT, 0, 0, 0, 0, 1); expect_trap("R6 mach", 1, 4'd11);
        issue(1, 2'b01, FS_INIT, 0, 0, 0, 0, 1); expect_trap("R6 supv", 1, 4'd9);
        issue(1, 2'b00, FS_INIT, 0, 0, 0, 0, 1); expect_trap("R6 user", 1, 4'd8);
    endtask

    task automatic t_priority;
        issue(1, 2'b01, TVM, 0, 1, 0, 1, 1);           expect_trap("R7 fp first", 1, 4'd2);
        issue(1, 2'b01, TVM | FS_INIT, 0, 0, 1, 0, 1); expect_trap("R7 vm over env", 1, 4'd2);
        issue(1, 2'b01, FS_INIT, 1, 0, 0, 0, 1);       expect_trap("R7 env only", 1, 4'd9);
    endtask

    task automatic t_bubble;
        issue(0, 2'b01, TVM, 1, 1, 1, 1, 1); expect_trap("R8", 0, 4'd0);
    endtask

    task automatic t_dirty;
        issue(0, 2'b11, 64'h0000_0000_0010_6000, 0, 0, 0, 0, 0);
        cmp("R9 dirty", status_rd, 64'h8000_0000_0010_6000);
        issue(0, 2'b11, 64'h8000_0000_0000_4000, 0, 0, 0, 0, 0);
        cmp("R9 fs10", status_rd, 64'h0000_0000_0000_4000);
        issue(0, 2'b11, 64'h8000_0000_0000_0001, 0, 0, 0, 0, 0);
        cmp("R9 off", status_rd, 64'h0000_0000_0000_0001);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_tvm_supervisor();
        t_tvm_inert();
        t_fp_gate();
        t_ecall();
        t_priority();
        t_bubble();
        t_dirty();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule